// File: doc/BRIEF.md
# ARINC 429 Receive Word Holding Buffer

This block sits behind a serial bit recovery stage. That stage hands it one qualified data bit at a time and then a single end-of-word pulse. The block shifts the bits into a 32-bit register. When the end-of-word pulse arrives, it forms the stored word: the last received bit (ARINC bit 32) is replaced by a parity-check result. The block can optionally compare ARINC bits 9 and 10 against two programmed bits. A word that is accepted is copied into a holding latch, and an active-low ready output goes low.

A host collects the word over a 16-bit bus. It raises a read strobe and uses a half-select line to choose which 16-bit half to read. The ready output returns high only after both halves of the held word have been read. If a newer word is accepted before that happens, the newer word replaces the held one and ready stays low. A synchronous configuration write loads the filter enable and the two match bits.

Top module: `arw_word_buffer`

## Requirements
- R1: After reset, data_ready_n is 1, rd_data is zero, the held word is zero and the label filter is disabled with match bits 00.
- R2: Each cycle with bit_valid high shifts bit_data in. The first of 32 bits lands at word index 0 (ARINC bit 1) and the last at index 31. A bit presented in the same cycle as eos is not part of the word captured by that eos.
- R3: The stored index 31 is 0 when the number of ones among the 32 received bits, the received bit 32 included, is odd, and 1 when that number is even.
- R4: With the filter enabled, an eos is accepted only if word index 9 equals cfg_match[1] and index 8 equals cfg_match[0]. A rejected eos leaves the held word, data_ready_n and the read progress unchanged.
- R5: With the filter disabled, every eos is accepted.
- R6: An accepted eos loads the held word and drives data_ready_n low from the next cycle.
- R7: With rd_en high, rd_data shows held word bits 15:0 when rd_half is 0 and bits 31:16 when rd_half is 1. With rd_en low, rd_data is zero.
- R8: While ready, each cycle with rd_en high marks the selected half as read. data_ready_n returns to 1 in the cycle after the second distinct half is read, in either order. Repeated reads of the same half do not clear it.
- R9: A word accepted while data_ready_n is low replaces the held word, keeps data_ready_n low and discards the halves already read.
- R10: cfg_we high registers cfg_filter_en and cfg_match at the clock edge. An eos in that same cycle is judged with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A qualified data bit is present |
| bit_data | input | 1 | Value of the qualified bit |
| eos | input | 1 | End-of-word pulse from the bit sequencer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_filter_en | input | 1 | Enable the label-bit match filter |
| cfg_match | input | 2 | Expected value of word bits 9 (MSB) and 8 |
| rd_en | input | 1 | Host read strobe |
| rd_half | input | 1 | Half select: 0 selects bits 15:0, 1 selects bits 31:16 |
| rd_data | output | 16 | Selected half of the held word, zero when idle |
| data_ready_n | output | 1 | Low while a held word has not been fully read |

## Verification
The hardest situation to reach from the ports is a word completing part-way through a two-half read. In that case the read progress must reset, so one more read of the remaining half must not clear ready. The stimulus reads one half, delivers a full new word, and then reads only the other half before finishing with the first. Two further cases need precise placement: eos in the same cycle as a configuration write, and eos in the same cycle as a last bit. The driving tasks place these edges on exact cycles, and a behavioural queue model predicts both outputs on every clock.

// File: rtl/arw_pkg.sv
package arw_pkg;
   localparam int MATCH_W = 2;

   typedef struct packed {
      logic               filt_en;
      logic [MATCH_W-1:0] match;
   } arw_cfg_t;
endpackage

// File: rtl/arw_shift.sv
module arw_shift #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_data,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] sr_q;
   logic [WORD_W:0]   chain;

   always_ff @(posedge clk) begin
      if (!rst_n)         sr_q <= '0;
      else if (bit_valid) sr_q <= {bit_data, sr_q[WORD_W-1:1]};
   end

   assign chain[0] = 1'b0;
   for (genvar g = 0; g < WORD_W; g++) begin : g_par
      assign chain[g+1] = chain[g] ^ sr_q[g];
   end

   assign word_o = {~chain[WORD_W], sr_q[WORD_W-2:0]};

   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> sr_q[WORD_W-1] == $past(bit_data));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> $stable(sr_q));
endmodule

// File: rtl/arw_filter.sv
module arw_filter
   import arw_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SEL_LO = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  arw_cfg_t          cfg_in,
   input  logic              eos,
   input  logic [WORD_W-1:0] word_i,
   output logic              accept
);
   if (SEL_LO + MATCH_W > WORD_W) begin : g_bad_sel
      $error("label field lies outside the word");
   end

   arw_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_in;
   end

   logic hit;
   assign hit    = (word_i[SEL_LO +: MATCH_W] == cfg_q.match);
   assign accept = eos && (!cfg_q.filt_en || hit);

   a_r5_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (eos && !cfg_q.filt_en) |-> accept);
   a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_q == $past(cfg_in));
   a_r4_no_accept_without_eos: assert property (@(posedge clk) disable iff (!rst_n)
      !eos |-> !accept);
endmodule

// File: rtl/arw_readout.sv
module arw_readout #(
   parameter int WORD_W = 32,
   parameter int BUS_W  = 16,
   parameter int SEL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [WORD_W-1:0] word_i,
   input  logic              rd_en,
   input  logic [SEL_W-1:0]  rd_half,
   output logic [BUS_W-1:0]  rd_data,
   output logic              ready
);
   localparam int NHALF = WORD_W / BUS_W;

   if (NHALF * BUS_W != WORD_W || NHALF < 2) begin : g_bad_split
      $error("word must split into two or more whole bus halves");
   end
   if ((1 << SEL_W) < NHALF) begin : g_bad_sel
      $error("half select too narrow");
   end

   logic [WORD_W-1:0] latch_q;
   logic [NHALF-1:0]  done_q, done_nx, rd_hit;
   logic [BUS_W-1:0]  half_w [NHALF];
   logic              sel_ok;

   assign sel_ok = int'(rd_half) < NHALF;

   always_comb begin
      rd_hit = '0;
      if (rd_en && sel_ok) rd_hit[rd_half] = 1'b1;
      done_nx = done_q | (ready ? rd_hit : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         ready   <= 1'b0;
         done_q  <= '0;
      end else if (accept) begin
         latch_q <= word_i;
         ready   <= 1'b1;
         done_q  <= '0;
      end else if (ready && (&done_nx)) begin
         ready  <= 1'b0;
         done_q <= '0;
      end else begin
         done_q <= done_nx;
      end
   end

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      assign half_w[h] = latch_q[h*BUS_W +: BUS_W];
   end

   assign rd_data = (rd_en && sel_ok) ? half_w[rd_half] : '0;

   a_r6_accept_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ready);
   a_r6_rise_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(accept));
   a_r8_clear_after_all: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !accept && (&done_nx)) |=> !ready);
   a_r9_hold_partial: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !(&done_nx)) |=> ready);
   a_r4_latch_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(latch_q) |-> $past(accept));
endmodule

// File: rtl/arw_word_buffer.sv
module arw_word_buffer
   import arw_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int BUS_W  = 16,
   parameter int SEL_LO = 8,
   parameter int SEL_W  = $clog2(WORD_W / BUS_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_valid,
   input  logic               bit_data,
   input  logic               eos,
   input  logic               cfg_we,
   input  logic               cfg_filter_en,
   input  logic [MATCH_W-1:0] cfg_match,
   input  logic               rd_en,
   input  logic [SEL_W-1:0]   rd_half,
   output logic [BUS_W-1:0]   rd_data,
   output logic               data_ready_n
);
   logic [WORD_W-1:0] word_w;
   logic              accept_w;
   logic              ready_w;
   arw_cfg_t          cfg_w;

   assign cfg_w = '{filt_en: cfg_filter_en, match: cfg_match};

   arw_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid),
      .bit_data(bit_data), .word_o(word_w)
   );

   arw_filter #(.WORD_W(WORD_W), .SEL_LO(SEL_LO)) u_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_w),
      .eos(eos), .word_i(word_w), .accept(accept_w)
   );

   arw_readout #(.WORD_W(WORD_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_readout (
      .clk(clk), .rst_n(rst_n), .accept(accept_w), .word_i(word_w),
      .rd_en(rd_en), .rd_half(rd_half), .rd_data(rd_data), .ready(ready_w)
   );

   assign data_ready_n = ~ready_w;

   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_data == '0);
endmodule

// File: tb/arw_word_buffer_tb_top.sv
`timescale 1ns/1ps
module arw_word_buffer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_valid = 0, bit_data = 0, eos = 0;
   logic        cfg_we = 0, cfg_filter_en = 0;
   logic [1:0]  cfg_match = 0;
   logic        rd_en = 0;
   logic [0:0]  rd_half = 0;
   logic [15:0] rd_data;
   logic        data_ready_n;

   int vectors = 0, fails = 0, cyc = 0;
   bit started = 0, finished = 0;
   string cur_tag = "R1";

   always #2.5 clk = ~clk;

   arw_word_buffer dut_i (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
      .eos(eos), .cfg_we(cfg_we), .cfg_filter_en(cfg_filter_en),
      .cfg_match(cfg_match), .rd_en(rd_en), .rd_half(rd_half),
      .rd_data(rd_data), .data_ready_n(data_ready_n)
   );

   // behavioural reference model
   bit          q[$];
   logic [31:0] m_latch;
   bit          m_ready;
   bit [1:0]    m_done;
   bit          m_fe;
   bit [1:0]    m_match;

   always @(posedge clk) begin : model
      logic [31:0] w;
      int ones;
      bit acc;
      if (!rst_n) begin
         q.delete();
         for (int i = 0; i < 32; i++) q.push_back(1'b0);
         m_latch = 0; m_ready = 0; m_done = 0; m_fe = 0; m_match = 0;
      end else begin
         ones = 0;
         for (int i = 0; i < 32; i++) begin
            w[i] = q[i];
            if (q[i]) ones++;
         end
         w[31] = (ones % 2 == 1) ? 1'b0 : 1'b1;
         acc = eos && (!m_fe || (w[9] == m_match[1] && w[8] == m_match[0]));
         if (acc) begin
            m_latch = w; m_ready = 1; m_done = 0;
         end else if (m_ready && rd_en) begin
            m_done[rd_half] = 1'b1;
            if (m_done == 2'b11) begin m_ready = 0; m_done = 0; end
         end
         if (bit_valid) begin
            q.push_back(bit_data);
            void'(q.pop_front());
         end
         if (cfg_we) begin m_fe = cfg_filter_en; m_match = cfg_match; end
      end
      started = 1;
   end

   always @(negedge clk) begin : compare
      logic [15:0] exp_d;
      if (started && !finished) begin
         exp_d = !rd_en ? 16'h0 : (rd_half ? m_latch[31:16] : m_latch[15:0]);
         vectors++;
         if (data_ready_n !== !m_ready) begin
            fails++;
            $display("FAIL %s data_ready_n actual %b expected %b", cur_tag, data_ready_n, !m_ready);
         end
         vectors++;
         if (rd_data !== exp_d) begin
            fails++;
            $display("FAIL %s rd_data actual %h expected %h", cur_tag, rd_data, exp_d);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic send_word(input logic [31:0] w, input bit eos_on_last);
      for (int i = 0; i < 32; i++) begin
         step(); bit_valid = 1; bit_data = w[i];
         if (i == 31 && eos_on_last) eos = 1;
         step(); bit_valid = 0; eos = 0;
      end
      if (!eos_on_last) begin
         step(); eos = 1;
         step(); eos = 0;
      end
   endtask

   task automatic rd(input bit half);
      step(); rd_en = 1; rd_half = half;
      step(); rd_en = 0;
      step();
   endtask

   task automatic cfg(input bit fe, input logic [1:0] m);
      step(); cfg_we = 1; cfg_filter_en = fe; cfg_match = m;
      step(); cfg_we = 0;
   endtask

   initial begin
      cur_tag = "R1";
      repeat (3) step();
      rst_n = 1;
      repeat (3) step();
      rd(0); rd(1);                                  // R1: idle reads give zero

      cur_tag = "R5";                                // R5, R2, R3: filter off
      send_word(32'h8123_4567, 0);
      cur_tag = "R6";  repeat (2) step();
      cur_tag = "R7";  rd(0);
      cur_tag = "R8";  rd(0); rd(0); rd(1);          // repeats do not clear
      cur_tag = "R3";  send_word(32'h0000_0003, 0);  // even ones -> bit 31 set
      rd(1); rd(0);
      cur_tag = "R2";  send_word(32'h1234_5679, 0);
      rd(1); rd(0);

      cur_tag = "R10"; cfg(1, 2'b10);
      cur_tag = "R4";
      send_word(32'h0000_0100, 0);                   // bits 9,8 = 01 -> rejected
      repeat (3) step();
      send_word(32'h0000_0200, 0);                   // bits 9,8 = 10 -> accepted
      rd(0);
      send_word(32'hFFFF_FDFF, 0);                   // bits 9,8 = 01 -> rejected, progress kept
      rd(1);

      cur_tag = "R9";
      send_word(32'hA5A5_A6A5, 0);                   // match 10
      rd(0);
      send_word(32'h5A5A_5EDA, 0);                   // overwrite mid-read
      rd(1); repeat (2) step();                      // still ready
      rd(0);

      cur_tag = "R10";                               // cfg write together with eos
      send_word(32'h0000_0100, 1);
      step(); cfg_we = 1; cfg_filter_en = 0; cfg_match = 0; eos = 1;
      step(); cfg_we = 0; eos = 0;
      repeat (2) step();
      rd(0); rd(1);
      step(); eos = 1;
      step(); eos = 0;
      repeat (2) step();
      rd(1); rd(0);

      cur_tag = "R2";                                // eos shares the last bit cycle
      send_word(32'hC3C3_3C3C, 1);
      repeat (2) step();
      rd(0); rd(1);

      cur_tag = "R1";
      rst_n = 0; repeat (2) step(); rst_n = 1;
      repeat (2) step(); rd(0); rd(1);

      repeat (3) step();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule